// File: doc/BRIEF.md
# Banked Level Interrupt Router

This block gathers level-sensitive interrupt lines in banks of 32 and turns them into four interrupt outputs. Two targets are served: a main processor and a coprocessor. Each target has an IRQ output and a fast FIQ output. For every line, each target has an enable bit and a class bit. The class bit chooses whether the line drives that target's IRQ or its FIQ. Software can also force any line active with no hardware input present.

Enable bits and force bits are changed through separate set-mask and clear-mask addresses. Several agents can therefore change individual bits without a read-modify-write race. The class registers are written directly. A read-only status word shows which lines the main processor currently sees as FIQ. The bank count is a parameter (up to six), and the address bits above `BANK_SHIFT` select the bank.

Top module: `ictl_top`

## Requirements
- R1: After reset, every enable, force and class bit reads zero and all four outputs are low.
- R2: Writing a mask to offset 0x24 sets the main-processor enable bits where the mask is 1 and leaves the others unchanged; the enables read back at offset 0x20.
- R3: Writing a mask to offset 0x28 clears the main-processor enable bits where the mask is 1 and leaves the others unchanged; writing all ones disables every line of the bank in one access.
- R4: The force word reads at offset 0x14, is set by mask at 0x18 and cleared by mask at 0x1C. A line's request is its input ORed with its force bit, so a forced line requests with its input low.
- R5: The main-processor class word at offset 0x2C is plain read/write; bit value 0 steers that line to `cpu_irq`, value 1 to `cpu_fiq`.
- R6: The coprocessor has its own enable word (read 0x30, set 0x34, clear 0x38) and class word (0x3C), with the same meaning as R2, R3 and R5. It drives only `cop_irq` and `cop_fiq`, and its state never affects the main-processor outputs (nor the reverse).
- R7: Each output is registered. At every clock edge it takes the OR, over all lines of all banks, of request & enable & ~class (IRQ) or request & enable & class (FIQ) as they stood before that edge.
- R8: Offset 0x08 reads request & main enable & main class for the bank. It is read-only: a write there changes no register.
- R9: The set and clear addresses (0x18, 0x1C, 0x24, 0x28, 0x34, 0x38) and any unmapped offset read as zero. A write to an unmapped offset is ignored.
- R10: Line N belongs to bank N/32 at bit N%32 of every word. Bank b is located at address b·2^BANK_SHIFT. Accesses to a bank index at or above NUM_BANKS read zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address: bank index above BANK_SHIFT, register offset below |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_src | input | NUM_BANKS*32 | Raw level interrupt lines, line N at bit N |
| cpu_irq | output | 1 | Main-processor normal interrupt |
| cpu_fiq | output | 1 | Main-processor fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |

## Verification
The assertions check on every cycle that each output equals the steered request of the previous cycle. In bank 0 they also check three things: a set or clear mask touches only its own bits, a write to the status word leaves the state alone, and the alias addresses read zero. The bench scenarios cover the rest. They mix random masks, class values, force values and inputs across all banks, and compare the results with a bench model. Only these scenarios can show bank addressing, ignored writes beyond the last bank, and independence between the two targets across many lines.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int LINES = 32;
    typedef logic [LINES-1:0] word_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VFIQ,
        SEL_FRC,
        SEL_FRC_SET,
        SEL_FRC_CLR,
        SEL_CEN,
        SEL_CEN_SET,
        SEL_CEN_CLR,
        SEL_CCLS,
        SEL_PEN,
        SEL_PEN_SET,
        SEL_PEN_CLR,
        SEL_PCLS
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [7:0] off);
        reg_sel_e s;
        case (off)
            8'h08:   s = SEL_VFIQ;
            8'h14:   s = SEL_FRC;
            8'h18:   s = SEL_FRC_SET;
            8'h1C:   s = SEL_FRC_CLR;
            8'h20:   s = SEL_CEN;
            8'h24:   s = SEL_CEN_SET;
            8'h28:   s = SEL_CEN_CLR;
            8'h2C:   s = SEL_CCLS;
            8'h30:   s = SEL_PEN;
            8'h34:   s = SEL_PEN_SET;
            8'h38:   s = SEL_PEN_CLR;
            8'h3C:   s = SEL_PCLS;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/ictl_setclr_reg.sv
module ictl_setclr_reg
    import ictl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_mask,
    input  word_t clr_mask,
    input  logic  load_en,
    input  word_t load_val,
    output word_t q
);
    word_t q_next;

    always_comb begin
        if (load_en) q_next = load_val;
        else         q_next = (q | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/ictl_bank.sv
module ictl_bank
    import ictl_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int BANK_SHIFT = 8,
    parameter int BANK_ID    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  word_t             bus_wdata,
    input  word_t             src,
    output word_t             rd_word,
    output word_t             cpu_irq_v,
    output word_t             cpu_fiq_v,
    output word_t             cop_irq_v,
    output word_t             cop_fiq_v,
    output word_t             cen_q,
    output word_t             ccls_q,
    output word_t             pen_q,
    output word_t             pcls_q,
    output word_t             frc_q
);
    localparam int IDX_W = ADDR_W - BANK_SHIFT;

    logic     hit;
    logic     wr_hit;
    reg_sel_e sel;
    word_t    req;
    logic [7:0] off;

    assign off    = 8'(bus_addr[BANK_SHIFT-1:0]);
    assign hit    = (bus_addr[ADDR_W-1:BANK_SHIFT] == IDX_W'(BANK_ID));
    assign sel    = decode_off(off);
    assign wr_hit = bus_wr & hit;

    function automatic word_t strobe(input reg_sel_e want);
        return (wr_hit && sel == want) ? bus_wdata : '0;
    endfunction

    ictl_setclr_reg u_frc (
        .clk(clk), .rst_n(rst_n),
        .set_mask(strobe(SEL_FRC_SET)), .clr_mask(strobe(SEL_FRC_CLR)),
        .load_en(1'b0), .load_val('0), .q(frc_q)
    );
    ictl_setclr_reg u_cen (
        .clk(clk), .rst_n(rst_n),
        .set_mask(strobe(SEL_CEN_SET)), .clr_mask(strobe(SEL_CEN_CLR)),
        .load_en(1'b0), .load_val('0), .q(cen_q)
    );
    ictl_setclr_reg u_pen (
        .clk(clk), .rst_n(rst_n),
        .set_mask(strobe(SEL_PEN_SET)), .clr_mask(strobe(SEL_PEN_CLR)),
        .load_en(1'b0), .load_val('0), .q(pen_q)
    );
    ictl_setclr_reg u_ccls (
        .clk(clk), .rst_n(rst_n),
        .set_mask('0), .clr_mask('0),
        .load_en(wr_hit && sel == SEL_CCLS), .load_val(bus_wdata), .q(ccls_q)
    );
    ictl_setclr_reg u_pcls (
        .clk(clk), .rst_n(rst_n),
        .set_mask('0), .clr_mask('0),
        .load_en(wr_hit && sel == SEL_PCLS), .load_val(bus_wdata), .q(pcls_q)
    );

    assign req       = src | frc_q;
    assign cpu_irq_v = req & cen_q & ~ccls_q;
    assign cpu_fiq_v = req & cen_q &  ccls_q;
    assign cop_irq_v = req & pen_q & ~pcls_q;
    assign cop_fiq_v = req & pen_q &  pcls_q;

    always_comb begin
        rd_word = '0;
        if (hit) begin
            unique case (sel)
                SEL_VFIQ: rd_word = cpu_fiq_v;
                SEL_FRC:  rd_word = frc_q;
                SEL_CEN:  rd_word = cen_q;
                SEL_CCLS: rd_word = ccls_q;
                SEL_PEN:  rd_word = pen_q;
                SEL_PCLS: rd_word = pcls_q;
                SEL_NONE, SEL_FRC_SET, SEL_FRC_CLR, SEL_CEN_SET,
                SEL_CEN_CLR, SEL_PEN_SET, SEL_PEN_CLR: rd_word = '0;
                default:  rd_word = '0;
            endcase
        end
    end
endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int BANK_SHIFT = 8,
    parameter int ADDR_W     = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_BANKS*LINES-1:0] irq_src,
    output logic                      cpu_irq,
    output logic                      cpu_fiq,
    output logic                      cop_irq,
    output logic                      cop_fiq
);
    localparam int TOTAL = NUM_BANKS * LINES;

    word_t rd_w   [NUM_BANKS];
    word_t ci_w   [NUM_BANKS];
    word_t cf_w   [NUM_BANKS];
    word_t pi_w   [NUM_BANKS];
    word_t pf_w   [NUM_BANKS];

    logic [TOTAL-1:0] cen_v, ccls_v, pen_v, pcls_v, frc_v;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ictl_bank #(
            .ADDR_W(ADDR_W), .BANK_SHIFT(BANK_SHIFT), .BANK_ID(b)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_wr    (bus_wr),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .src       (irq_src[b*LINES +: LINES]),
            .rd_word   (rd_w[b]),
            .cpu_irq_v (ci_w[b]),
            .cpu_fiq_v (cf_w[b]),
            .cop_irq_v (pi_w[b]),
            .cop_fiq_v (pf_w[b]),
            .cen_q     (cen_v[b*LINES +: LINES]),
            .ccls_q    (ccls_v[b*LINES +: LINES]),
            .pen_q     (pen_v[b*LINES +: LINES]),
            .pcls_q    (pcls_v[b*LINES +: LINES]),
            .frc_q     (frc_v[b*LINES +: LINES])
        );
    end

    logic ci_any, cf_any, pi_any, pf_any;

    always_comb begin
        bus_rdata = '0;
        ci_any = 1'b0;
        cf_any = 1'b0;
        pi_any = 1'b0;
        pf_any = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            bus_rdata = bus_rdata | rd_w[b];
            ci_any    = ci_any | (|ci_w[b]);
            cf_any    = cf_any | (|cf_w[b]);
            pi_any    = pi_any | (|pi_w[b]);
            pf_any    = pf_any | (|pf_w[b]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_irq <= 1'b0;
            cpu_fiq <= 1'b0;
            cop_irq <= 1'b0;
            cop_fiq <= 1'b0;
        end else begin
            cpu_irq <= ci_any;
            cpu_fiq <= cf_any;
            cop_irq <= pi_any;
            cop_fiq <= pf_any;
        end
    end
endmodule

// File: rtl/ictl_chk.sv
module ictl_chk #(
    parameter int TOTAL  = 96,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [TOTAL-1:0]  irq_src,
    input logic [TOTAL-1:0]  cen_v,
    input logic [TOTAL-1:0]  ccls_v,
    input logic [TOTAL-1:0]  pen_v,
    input logic [TOTAL-1:0]  pcls_v,
    input logic [TOTAL-1:0]  frc_v,
    input logic              cpu_irq,
    input logic              cpu_fiq,
    input logic              cop_irq,
    input logic              cop_fiq
);
    logic [TOTAL-1:0] rq;
    assign rq = irq_src | frc_v;

    AST_CPU_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_irq == $past(|(rq & cen_v & ~ccls_v))); // R7
    AST_CPU_FIQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_fiq == $past(|(rq & cen_v & ccls_v))); // R7
    AST_COP_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cop_irq == $past(|(rq & pen_v & ~pcls_v))); // R6
    AST_COP_FIQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cop_fiq == $past(|(rq & pen_v & pcls_v))); // R6
    AST_SET_MASK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(36)) |=>
        (cen_v[31:0] == ($past(cen_v[31:0]) | $past(bus_wdata)))); // R2
    AST_CLR_MASK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(40)) |=>
        (cen_v[31:0] == ($past(cen_v[31:0]) & ~$past(bus_wdata)))); // R3
    AST_VFIQ_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8)) |=>
        ($stable(cen_v) && $stable(ccls_v) && $stable(pen_v) &&
         $stable(pcls_v) && $stable(frc_v))); // R8
    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(24) || bus_addr == ADDR_W'(28) ||
         bus_addr == ADDR_W'(36) || bus_addr == ADDR_W'(40) ||
         bus_addr == ADDR_W'(52) || bus_addr == ADDR_W'(56)) |->
        bus_rdata == 32'h0); // R9
endmodule

bind ictl_top ictl_chk #(.TOTAL(NUM_BANKS*32), .ADDR_W(ADDR_W)) u_ictl_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .cen_v(cen_v), .ccls_v(ccls_v), .pen_v(pen_v), .pcls_v(pcls_v),
    .frc_v(frc_v), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
    .cop_irq(cop_irq), .cop_fiq(cop_fiq)
);

// File: tb/test_ictl_top.sv
`timescale 1ns/1ps
module test_ictl_top;
    localparam int NB = 3;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NB*32-1:0] irq_src = '0;
    logic cpu_irq, cpu_fiq, cop_irq, cop_fiq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_cen [NB];
    logic [31:0] m_ccls[NB];
    logic [31:0] m_pen [NB];
    logic [31:0] m_pcls[NB];
    logic [31:0] m_frc [NB];

    always #4 clk = ~clk;

    ictl_top #(.NUM_BANKS(NB), .BANK_SHIFT(8), .ADDR_W(AW)) i_ictl_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq), .cop_fiq(cop_fiq)
    );

    function automatic logic [AW-1:0] adr(input int bank, input int off);
        return AW'(bank * 256 + off);
    endfunction

    function automatic logic [3:0] exp_outs();
        logic [3:0] e = '0;
        for (int b = 0; b < NB; b++) begin
            logic [31:0] rq;
            rq = irq_src[b*32 +: 32] | m_frc[b];
            e[3] = e[3] | (|(rq & m_cen[b] & ~m_ccls[b]));
            e[2] = e[2] | (|(rq & m_cen[b] &  m_ccls[b]));
            e[1] = e[1] | (|(rq & m_pen[b] & ~m_pcls[b]));
            e[0] = e[0] | (|(rq & m_pen[b] &  m_pcls[b]));
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_outs(input string tag);
        chk(tag, {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, {28'h0, exp_outs()});
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            m_cen[b] = '0; m_ccls[b] = '0; m_pen[b] = '0; m_pcls[b] = '0; m_frc[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset state
        chk_outs("R1 outputs after reset");
        for (int b = 0; b < NB; b++) begin
            rd(adr(b, 8'h20), v); chk("R1 cpu enable reset", v, 32'h0);
            rd(adr(b, 8'h2C), v); chk("R1 cpu class reset", v, 32'h0);
            rd(adr(b, 8'h30), v); chk("R1 cop enable reset", v, 32'h0);
            rd(adr(b, 8'h3C), v); chk("R1 cop class reset", v, 32'h0);
            rd(adr(b, 8'h14), v); chk("R1 force reset", v, 32'h0);
        end

        // R2 / R3: set and clear masks
        wr(adr(0, 8'h24), 32'h0000_00F0); m_cen[0] = 32'h0000_00F0;
        wr(adr(0, 8'h24), 32'h8000_0001); m_cen[0] |= 32'h8000_0001;
        rd(adr(0, 8'h20), v); chk("R2 set mask keeps other bits", v, m_cen[0]);
        wr(adr(0, 8'h28), 32'h0000_0030); m_cen[0] &= ~32'h0000_0030;
        rd(adr(0, 8'h20), v); chk("R3 clear mask keeps other bits", v, m_cen[0]);
        wr(adr(0, 8'h28), 32'hFFFF_FFFF); m_cen[0] = '0;
        rd(adr(0, 8'h20), v); chk("R3 clear all", v, 32'h0);

        // R4: forced line requests with input low
        wr(adr(1, 8'h24), 32'h0000_0100); m_cen[1] = 32'h0000_0100;
        wr(adr(1, 8'h18), 32'h0000_0100); m_frc[1] = 32'h0000_0100;
        settle();
        chk("R4 forced line raises cpu_irq", {31'h0, cpu_irq}, 32'h1);
        rd(adr(1, 8'h14), v); chk("R4 force readback", v, 32'h0000_0100);

        // R5: class steers to FIQ; R8 status word
        wr(adr(1, 8'h2C), 32'h0000_0100); m_ccls[1] = 32'h0000_0100;
        settle();
        chk("R5 class 1 steers to fiq", {30'h0, cpu_irq, cpu_fiq}, 32'h1);
        rd(adr(1, 8'h08), v); chk("R8 status shows fiq line", v, 32'h0000_0100);
        wr(adr(1, 8'h08), 32'hFFFF_FFFF);
        rd(adr(1, 8'h20), v); chk("R8 status write ignored", v, m_cen[1]);
        rd(adr(1, 8'h2C), v); chk("R8 status write keeps class", v, m_ccls[1]);

        // R6: coprocessor independence
        chk("R6 cop idle while cpu active", {30'h0, cop_irq, cop_fiq}, 32'h0);
        wr(adr(1, 8'h34), 32'h0000_0100); m_pen[1] = 32'h0000_0100;
        settle();
        chk("R6 cop irq with its own class 0", {30'h0, cop_irq, cop_fiq}, 32'h2);
        wr(adr(1, 8'h1C), 32'h0000_0100); m_frc[1] = '0;
        settle();
        chk_outs("R4 unforce drops all outputs");

        // R9: alias and unmapped reads zero, unmapped write ignored
        rd(adr(1, 8'h24), v); chk("R9 set alias reads zero", v, 32'h0);
        rd(adr(1, 8'h38), v); chk("R9 clear alias reads zero", v, 32'h0);
        rd(adr(1, 8'h04), v); chk("R9 unmapped offset reads zero", v, 32'h0);
        wr(adr(1, 8'h40), 32'hFFFF_FFFF);
        rd(adr(1, 8'h30), v); chk("R9 unmapped write ignored", v, m_pen[1]);

        // R10: bank beyond NUM_BANKS, bank mapping
        wr(adr(3, 8'h24), 32'hFFFF_FFFF);
        rd(adr(3, 8'h20), v); chk("R10 absent bank reads zero", v, 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd(adr(b, 8'h20), v); chk("R10 absent bank write ignored", v, m_cen[b]);
        end
        irq_src[2*32 + 5] = 1'b1;
        wr(adr(2, 8'h24), 32'h0000_0020); m_cen[2] = 32'h0000_0020;
        settle();
        chk("R10 line 69 maps to bank 2 bit 5", {31'h0, cpu_irq}, 32'h1);
        chk_outs("R7 outputs after bank 2 line");

        // random phase: R7 model comparison
        for (int i = 0; i < 400; i++) begin
            int b;
            int op;
            logic [31:0] m;
            b = int'($urandom % NB);
            op = int'($urandom % 9);
            m = $urandom & $urandom;
            case (op)
                0: begin wr(adr(b, 8'h24), m); m_cen[b] |= m; end
                1: begin wr(adr(b, 8'h28), m); m_cen[b] &= ~m; end
                2: begin wr(adr(b, 8'h18), m & $urandom); m_frc[b] = i_frc_update(m_frc[b]); end
                3: begin wr(adr(b, 8'h1C), m); m_frc[b] &= ~m; end
                4: begin wr(adr(b, 8'h2C), m); m_ccls[b] = m; end
                5: begin wr(adr(b, 8'h34), m); m_pen[b] |= m; end
                6: begin wr(adr(b, 8'h38), m); m_pen[b] &= ~m; end
                7: begin wr(adr(b, 8'h3C), $urandom); m_pcls[b] = bus_wdata; end
                default: begin
                    @(negedge clk);
                    irq_src[b*32 +: 32] = $urandom & $urandom & $urandom;
                end
            endcase
            settle();
            chk_outs("R7 random outputs vs model");
            rd(adr(b, 8'h08), v);
            chk("R8 random status word",
                v, (irq_src[b*32 +: 32] | m_frc[b]) & m_cen[b] & m_ccls[b]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [31:0] i_frc_update(input logic [31:0] cur);
        return cur | bus_wdata;
    endfunction
endmodule